// File: doc/BRIEF.md
# Synchronous Serial Byte Shifter

This block moves one byte at a time over a three-wire synchronous link: a clock line, a serial input and a serial output. As clock master it generates the link clock from the system clock through an 8-bit prescaler. As clock slave it shifts on a clock supplied from outside. When one end of a link is master, the other end must be slave, and the block can fill either role.

Software programs a prescaler, loads a byte into the shift register and writes the control register to start. Bits leave on the serial output on each falling link-clock edge. Bits are taken from the serial input on each rising edge. A 3-bit counter tracks the bit position. After the eighth bit the block sets a done flag, pulses the interrupt line for one cycle and stops shifting until software starts it again. The received byte can then be read from the data register. A receive-only mode holds the output line idle while still capturing input bits. The bit order can be MSB-first or LSB-first. An external link clock passes through a two-flop synchroniser and an edge detector, so the whole block runs on one system clock.

Top module: `sio_port`

## Requirements
- R1: After reset, the control register reads 00h, which selects the internal clock, receive-only mode, MSB-first order and shifting off. The prescaler and data registers read 00h, `so_o` and `sck_o` are 1, and `irq_o` is 0.
- R2: With the internal clock selected and shifting on, `sck_o` idles high and has a period of exactly 4*(prescaler+1) system clock cycles. This is the system rate divided by 4, then divided by prescaler+1.
- R3: After eight rising link-clock edges, the done flag (control bit 7) is set and `irq_o` is high for exactly one cycle. The run bit (control bit 0) reads 0, `sck_o` rests high and no further edges are produced.
- R4: With control bit 3 = 0 (MSB-first), data bit 7 appears on `so_o` first. Each received bit enters at bit 0, so after a byte the data register holds the partner's byte.
- R5: With control bit 3 = 1 (LSB-first), data bit 0 appears on `so_o` first. Received bits enter at bit 7 and move down, so the partner's byte again ends up intact.
- R6: With control bit 1 = 0 (receive-only), `so_o` stays at 1 for the whole transfer. Input bits are still shifted into the data register.
- R7: With control bit 2 = 1 (external clock), bits are shifted on the edges of `sck_i` and `sck_o` stays at 1.
- R8: While the run bit is 0, toggling `sck_i` and `si_i` leaves the data register, `so_o`, `sck_o` and `irq_o` unchanged.
- R9: Any write to the control register clears the bit counter, so the next byte needs a full eight edges. A write with the run bit set also clears the done flag.
- R10: Register map: address 0 is control, address 1 is prescaler, address 2 is data. The control fields are bit 0 run, bit 1 transmit, bit 2 external clock, bit 3 LSB-first and bit 7 done (read-only). These fields read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| sck_o | output | 1 | Link clock driven in master mode |
| sck_i | input | 1 | Link clock received in slave mode |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| irq_o | output | 1 | One-cycle byte-complete pulse |

## Verification
The hardest case to reach from the ports is a control write that lands partway through a byte. That write must restart the bit count without producing a spurious completion. The stimulus gets there as slave: it feeds three external clock edges, rewrites the control register, and then checks that the interrupt stays low through seven further edges and fires only on the eighth. A bench-side partner follows the link clock in both roles. It drives the input line on falling edges, rebuilds the output byte on rising edges, and measures the master clock period edge to edge.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_PSC  = 2'd1,
        REG_DATA = 2'd2
    } reg_sel_e;

    localparam int CTL_RUN  = 0;
    localparam int CTL_TX   = 1;
    localparam int CTL_EXT  = 2;
    localparam int CTL_LSB  = 3;
    localparam int CTL_DONE = 7;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);
    localparam int CNT_W = PSC_W + 2;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] half_len;

    // half a link-clock period lasts 2*(psc+1) system cycles
    always_comb begin
        half_len = {1'b0, psc_i, 1'b0} + CNT_W'(2);
        tick_o   = run_i && (cnt_q == half_len - CNT_W'(1));
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic         rise_o,
    output logic         fall_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];
    logic         prev_d, prev_q;

    always_comb begin
        stg_d[0] = d_i;
        prev_d   = stg_q[STAGES-1][0];
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        always_comb stg_d[i] = stg_q[i-1];
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_flop
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= '1;
            else        stg_q[i] <= stg_d[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign q_o    = stg_q[STAGES-1];
    assign rise_o = stg_q[STAGES-1][0] && !prev_q;
    assign fall_o = !stg_q[STAGES-1][0] && prev_q;
endmodule

// File: rtl/sio_port.sv
module sio_port #(
    parameter int DATA_W      = 8,
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sck_o,
    input  logic              sck_i,
    input  logic              si_i,
    output logic              so_o,
    output logic              irq_o
);
    import sio_pkg::*;

    localparam int BCNT_W = $clog2(DATA_W);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(DATA_W - 1);

    typedef struct packed {
        logic              run;
        logic              tx;
        logic              ext;
        logic              lsb;
        logic              done;
        logic [PSC_W-1:0]  psc;
        logic [DATA_W-1:0] sr;
        logic [BCNT_W-1:0] bcnt;
        logic              sck;
        logic              so;
        logic              irq;
    } st_t;

    st_t st_d, st_q;

    logic       baud_tick;
    logic [1:0] sync_q;
    logic       ext_rise, ext_fall;
    logic       rise_ev, fall_ev;
    logic       si_bit, out_bit;

    sio_baud #(.PSC_W(PSC_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.run && !st_q.ext),
        .psc_i  (st_q.psc),
        .tick_o (baud_tick)
    );

    // bit 0 carries the link clock, bit 1 the data so both see equal delay
    sio_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    ({si_i, sck_i}),
        .q_o    (sync_q),
        .rise_o (ext_rise),
        .fall_o (ext_fall)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        rise_ev  = 1'b0;
        fall_ev  = 1'b0;
        si_bit   = st_q.ext ? sync_q[1] : si_i;
        out_bit  = st_q.lsb ? st_q.sr[0] : st_q.sr[DATA_W-1];

        if (st_q.run) begin
            if (st_q.ext) begin
                rise_ev = ext_rise;
                fall_ev = ext_fall;
            end else if (baud_tick) begin
                fall_ev = st_q.sck;
                rise_ev = !st_q.sck;
            end
        end

        if (fall_ev) begin
            if (!st_q.ext) st_d.sck = 1'b0;
            st_d.so = st_q.tx ? out_bit : 1'b1;
        end

        if (rise_ev) begin
            if (!st_q.ext) st_d.sck = 1'b1;
            st_d.sr = st_q.lsb ? {si_bit, st_q.sr[DATA_W-1:1]}
                               : {st_q.sr[DATA_W-2:0], si_bit};
            if (st_q.bcnt == LAST_BIT) begin
                st_d.bcnt = '0;
                st_d.done = 1'b1;
                st_d.irq  = 1'b1;
                st_d.run  = 1'b0;
            end else begin
                st_d.bcnt = st_q.bcnt + BCNT_W'(1);
            end
        end

        if (wr_en) begin
            case (reg_sel_e'(addr))
                REG_CTRL: begin
                    st_d.run  = wdata[CTL_RUN];
                    st_d.tx   = wdata[CTL_TX];
                    st_d.ext  = wdata[CTL_EXT];
                    st_d.lsb  = wdata[CTL_LSB];
                    st_d.bcnt = '0;
                    st_d.sck  = 1'b1;
                    if (wdata[CTL_RUN]) st_d.done = 1'b0;
                    if (!wdata[CTL_TX]) st_d.so   = 1'b1;
                end
                REG_PSC:  st_d.psc = wdata[PSC_W-1:0];
                REG_DATA: st_d.sr  = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.sck <= 1'b1;
            st_q.so  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            REG_CTRL: begin
                rdata[CTL_RUN]  = st_q.run;
                rdata[CTL_TX]   = st_q.tx;
                rdata[CTL_EXT]  = st_q.ext;
                rdata[CTL_LSB]  = st_q.lsb;
                rdata[CTL_DONE] = st_q.done;
            end
            REG_PSC:  rdata[PSC_W-1:0] = st_q.psc;
            REG_DATA: rdata = st_q.sr;
            default:  rdata = '0;
        endcase
    end

    assign sck_o = st_q.sck;
    assign so_o  = st_q.so;
    assign irq_o = st_q.irq;

    logic run_w, tx_w, ext_w, done_w;
    assign run_w  = st_q.run;
    assign tx_w   = st_q.tx;
    assign ext_w  = st_q.ext;
    assign done_w = st_q.done;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_o,
    input logic sck_o,
    input logic so_o,
    input logic run_w,
    input logic tx_w,
    input logic ext_w,
    input logic done_w
);
    // R3
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R3
    irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (done_w && !run_w));

    // R6
    rx_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_w |-> so_o);

    // R7
    ext_sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_w |-> sck_o);

    // R8
    stopped_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && sck_o) |=> sck_o);

    // R8
    stopped_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |=> !irq_o);
endmodule

bind sio_port sio_port_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_o  (irq_o),
    .sck_o  (sck_o),
    .so_o   (so_o),
    .run_w  (run_w),
    .tx_w   (tx_w),
    .ext_w  (ext_w),
    .done_w (done_w)
);

// File: tb/sio_port_tb.sv
module sio_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       sck_o, so_o, irq_o;
    logic       sck_i = 1'b1;
    logic       si_i = 1'b1;

    int n_checks = 0;
    int n_errors = 0;

    // partner configuration shared with the monitor
    bit       mon_en = 1'b0;
    bit       ext_cfg = 1'b0;
    bit       lsb_cfg = 1'b0;
    logic [7:0] partner = 8'h00;
    int       exp_period = 4;
    logic [7:0] exp_q [$];
    int       irq_cnt = 0;

    sio_port u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .sck_o (sck_o),
        .sck_i (sck_i),
        .si_i  (si_i),
        .so_o  (so_o),
        .irq_o (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: acts as link partner and scoreboard consumer
    bit         line_prev = 1'b1;
    bit         irq_prev = 1'b0;
    bit         fall_seen = 1'b0;
    logic [7:0] so_acc = 8'h00;
    int         so_cnt = 0;
    int         si_idx = 0;
    int         cyc = 0;
    int         last_fall = 0;

    always @(negedge clk) begin
        cyc++;
        if (irq_o) begin
            irq_cnt++;
            if (irq_prev) chk(1'b0, "R3 irq width", 2, 1);
        end
        irq_prev = irq_o;
        if (!mon_en) begin
            line_prev = 1'b1;
            fall_seen = 1'b0;
            so_cnt    = 0;
            si_idx    = 0;
            si_i      = 1'b1;
        end else begin
            automatic bit line = ext_cfg ? sck_i : sck_o;
            if (line && !line_prev) begin
                so_acc = lsb_cfg ? {so_o, so_acc[7:1]} : {so_acc[6:0], so_o};
                so_cnt++;
                if (so_cnt == 8) begin
                    so_cnt = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 extra byte on SO", so_acc, 0);
                    end else begin
                        automatic logic [7:0] e = exp_q.pop_front();
                        chk(so_acc == e, lsb_cfg ? "R5 SO byte" : "R4 SO byte", so_acc, e);
                    end
                end
            end
            if (!line && line_prev) begin
                if (!ext_cfg && fall_seen)
                    chk((cyc - last_fall) == exp_period, "R2 sck period",
                        cyc - last_fall, exp_period);
                last_fall = cyc;
                fall_seen = 1'b1;
                if (si_idx < 8) si_i = lsb_cfg ? partner[si_idx] : partner[7 - si_idx];
                si_idx++;
            end
            line_prev = line;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(posedge clk); #1;
        addr = a;
        @(negedge clk);
        chk(rdata === exp, req, rdata, exp);
    endtask

    task automatic wait_irq(input int base);
        for (int i = 0; i < 20000 && irq_cnt <= base; i++) @(posedge clk);
    endtask

    task automatic ext_clocks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; sck_i = 1'b0;
            repeat (8) @(posedge clk);
            #1; sck_i = 1'b1;
            repeat (8) @(posedge clk);
        end
    endtask

    task automatic run_master(input logic [7:0] psc, input bit lsb, input bit tx,
                              input logic [7:0] data, input logic [7:0] pbyte);
        int base;
        wr(2'd1, psc);
        wr(2'd2, data);
        ext_cfg = 1'b0; lsb_cfg = lsb; partner = pbyte;
        exp_period = 4 * (int'(psc) + 1);
        exp_q.push_back(tx ? data : 8'hFF);
        mon_en = 1'b1;
        base = irq_cnt;
        wr(2'd0, {4'b0, lsb, 1'b0, tx, 1'b1});
        wait_irq(base);
        repeat (4 * (int'(psc) + 1) + 4) @(posedge clk);
        chk(irq_cnt == base + 1, "R3 one irq per byte", irq_cnt - base, 1);
        chk(sck_o === 1'b1, "R3 sck rests high", sck_o, 1);
        mon_en = 1'b0;
        chk(exp_q.size() == 0, "R3 eight bits seen", exp_q.size(), 0);
        exp_q.delete();
        rd(2'd0, {1'b1, 3'b0, lsb, 1'b0, tx, 1'b0}, "R3 done flag, run cleared");
        rd(2'd2, pbyte, lsb ? "R5 received byte" : "R4 received byte");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(so_o === 1'b1, "R1 so idle", so_o, 1);
        chk(sck_o === 1'b1, "R1 sck idle", sck_o, 1);
        chk(irq_o === 1'b0, "R1 irq low", irq_o, 0);
        rd(2'd0, 8'h00, "R1 ctrl reset");
        rd(2'd1, 8'h00, "R1 psc reset");
        rd(2'd2, 8'h00, "R1 data reset");

        // R10 readback
        wr(2'd0, 8'h0E);
        rd(2'd0, 8'h0E, "R10 ctrl fields");
        wr(2'd1, 8'h5C);
        rd(2'd1, 8'h5C, "R10 psc readback");
        wr(2'd0, 8'h00);

        // R2 R4 master MSB-first, fastest rate
        run_master(8'd0, 1'b0, 1'b1, 8'hA5, 8'h3C);
        // R5 master LSB-first
        run_master(8'd2, 1'b1, 1'b1, 8'h1E, 8'hC3);
        // R6 receive-only
        run_master(8'd1, 1'b0, 1'b0, 8'h55, 8'h9A);

        // R7 slave, transmit, MSB-first
        begin
            int base;
            int sck_lows;
            wr(2'd2, 8'h6B);
            ext_cfg = 1'b1; lsb_cfg = 1'b0; partner = 8'hD2;
            exp_q.push_back(8'h6B);
            mon_en = 1'b1;
            base = irq_cnt;
            wr(2'd0, 8'h07);
            sck_lows = 0;
            fork
                ext_clocks(8);
                for (int i = 0; i < 140; i++) begin
                    @(negedge clk);
                    if (sck_o !== 1'b1) sck_lows++;
                end
            join
            repeat (6) @(posedge clk);
            chk(sck_lows == 0, "R7 sck_o quiet in slave mode", sck_lows, 0);
            chk(irq_cnt == base + 1, "R7 slave completes", irq_cnt - base, 1);
            mon_en = 1'b0;
            chk(exp_q.size() == 0, "R7 slave SO byte seen", exp_q.size(), 0);
            exp_q.delete();
            rd(2'd0, 8'h86, "R7 ctrl after slave byte");
            rd(2'd2, 8'hD2, "R7 slave received byte");
        end

        // R9 control write clears done and restarts the count
        begin
            int base;
            wr(2'd2, 8'h00);
            wr(2'd0, 8'h05);
            rd(2'd0, 8'h05, "R9 done cleared by run write");
            ext_clocks(3);
            base = irq_cnt;
            wr(2'd0, 8'h05);
            ext_clocks(7);
            repeat (6) @(posedge clk);
            chk(irq_cnt == base, "R9 no irq after 7 restarted bits", irq_cnt - base, 0);
            ext_clocks(1);
            repeat (6) @(posedge clk);
            chk(irq_cnt == base + 1, "R9 irq on eighth restarted bit", irq_cnt - base, 1);
        end

        // R8 stopped: external edges have no effect
        begin
            int base;
            wr(2'd0, 8'h04);
            wr(2'd2, 8'h77);
            base = irq_cnt;
            for (int i = 0; i < 8; i++) begin
                @(posedge clk); #1; sck_i = 1'b0; si_i = i[0];
                repeat (6) @(posedge clk);
                #1; sck_i = 1'b1;
                repeat (6) @(posedge clk);
            end
            si_i = 1'b1;
            repeat (6) @(posedge clk);
            @(negedge clk);
            chk(irq_cnt == base, "R8 no irq while stopped", irq_cnt - base, 0);
            chk(sck_o === 1'b1, "R8 sck unchanged", sck_o, 1);
            chk(so_o === 1'b1, "R8 so unchanged", so_o, 1);
            rd(2'd2, 8'h77, "R8 data unchanged");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule